// File: doc/BRIEF.md
# Transmit Loop Repeat Controller

This block decides what a transmit channel does each time its symbol reader reaches the end of the stored sequence. A start strobe arms the channel. When the reader signals an end of sequence, the block does one of three things. In single-shot operation it ends the run with a done event. In continuous operation it asks the reader to rewind with a restart pulse. If pass counting is also on, it ends the run with a loop-end event once the programmed number of passes has completed.

The pass counter is cleared on every accepted start and by a one-cycle counter reset pulse. A stop strobe ends a run at any time and raises no event. All event outputs are single-cycle pulses. Each is registered, so it appears in the cycle after the end-of-sequence strobe that caused it. The symbol memory and the pulse generator sit outside this block.

Top module: `tx_loop_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, active_o, restart_o, done_o and loop_end_o are all 0.
- R2: A start_i pulse while idle, with stop_i low, sets active_o in the next cycle. A start_i pulse while active has no effect: active_o stays high and the pass count keeps its value.
- R3: With cont_en_i low, a seq_end_i pulse while active produces one done_o pulse in the next cycle. In that same cycle active_o drops, and restart_o and loop_end_o stay low. At most one of restart_o, done_o and loop_end_o is high in any cycle.
- R4: With cont_en_i high and cnt_en_i low, every seq_end_i pulse while active produces a restart_o pulse in the next cycle and active_o stays high, for any number of passes.
- R5: With cont_en_i and cnt_en_i high and loop_num_i = N with N of at least 1, passes 1 to N-1 each produce restart_o. Pass N produces a single loop_end_o pulse, with no done_o and no restart_o, and active_o drops in the same cycle.
- R6: With cnt_en_i high and loop_num_i = 0, no limit applies: every pass produces restart_o, as in R4.
- R7: A cnt_rst_i pulse sets the pass count to 0. An end of sequence in the same cycle as the pulse is not counted and produces restart_o.
- R8: stop_i clears active_o in the next cycle and no event pulse is raised. This holds even with seq_end_i or start_i in the same cycle.
- R9: seq_end_i while idle produces no pulse and leaves active_o low.
- R10: The limit is compared as "passes completed so far plus one is at least loop_num_i". If loop_num_i is lowered below the passes already made during a run, the next end of sequence produces loop_end_o.
- R11: An accepted start clears any pass count left over from an earlier stopped run, so the new run ends after a full N passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe, highest priority |
| seq_end_i | input | 1 | End-of-sequence strobe from the symbol reader |
| cont_en_i | input | 1 | Continuous (repeat) mode enable |
| cnt_en_i | input | 1 | Pass counting and limit enable |
| loop_num_i | input | CNT_W | Pass limit; 0 means no limit |
| cnt_rst_i | input | 1 | Pass counter clear pulse |
| active_o | output | 1 | Channel is running |
| restart_o | output | 1 | Rewind request to the symbol reader |
| done_o | output | 1 | Single-shot done event |
| loop_end_o | output | 1 | Pass limit reached event |

## Verification
The bench uses a 3-bit counter and sweeps every combination of the continuous and counting enables with every limit from 0 to 7. Each run gets nine end strobes, so the bench can tell done from restart from loop-end. It also shows exactly on which pass a run ends, and that strobes arriving after the end are ignored. Directed sequences then probe the orderings the sweep cannot reach: a counter reset in the middle of a run or in the same cycle as an end, a limit lowered during a run, a start while already running, and a stop that lands together with an end or a start. Together these separate a limit check that uses "equal" from one that uses "at least", and a start or reset that clears the count from one that does not.

// File: rtl/tx_loop_pkg.sv
package tx_loop_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  typedef struct packed {
    logic restart;
    logic done;
    logic loop_end;
  } loop_evt_t;
endpackage

// File: rtl/tx_loop_pass_cnt.sv
module tx_loop_pass_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   pass_nxt;

  assign pass_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // limit 0 means unbounded; a clear in the same cycle voids the pass
  assign last_o = cnt_en_i && (limit_i != '0) && !clr_i &&
                  (pass_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_loop_seq_fsm.sv
module tx_loop_seq_fsm
  import tx_loop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      seq_end_i,
  input  logic      cont_en_i,
  input  logic      last_i,
  output logic      active_o,
  output logic      start_acc_o,
  output logic      inc_o,
  output loop_evt_t evt_o
);
  run_state_e state_q, state_d;
  logic       end_ev;

  assign active_o    = (state_q == ST_RUN);
  assign start_acc_o = start_i && !stop_i && !active_o;
  assign end_ev      = seq_end_i && !stop_i && active_o;
  assign inc_o       = end_ev && cont_en_i && !last_i;

  always_comb begin
    state_d = state_q;
    evt_o   = '0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_acc_o) begin
      state_d = ST_RUN;
    end else if (end_ev) begin
      if (!cont_en_i) begin
        evt_o.done = 1'b1;
        state_d    = ST_IDLE;
      end else if (last_i) begin
        evt_o.loop_end = 1'b1;
        state_d        = ST_IDLE;
      end else begin
        evt_o.restart = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/tx_loop_evt_reg.sv
module tx_loop_evt_reg
  import tx_loop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  loop_evt_t evt_i,
  output loop_evt_t evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= evt_i;
  end
endmodule

// File: rtl/tx_loop_ctrl.sv
module tx_loop_ctrl
  import tx_loop_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             seq_end_i,
  input  logic             cont_en_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] loop_num_i,
  input  logic             cnt_rst_i,
  output logic             active_o,
  output logic             restart_o,
  output logic             done_o,
  output logic             loop_end_o
);
  logic      start_acc, inc, last;
  loop_evt_t evt_d, evt_q;

  tx_loop_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .seq_end_i   (seq_end_i),
    .cont_en_i   (cont_en_i),
    .last_i      (last),
    .active_o    (active_o),
    .start_acc_o (start_acc),
    .inc_o       (inc),
    .evt_o       (evt_d)
  );

  tx_loop_pass_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_acc | cnt_rst_i),
    .inc_i    (inc),
    .cnt_en_i (cnt_en_i),
    .limit_i  (loop_num_i),
    .last_o   (last)
  );

  tx_loop_evt_reg u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_d),
    .evt_o  (evt_q)
  );

  assign restart_o  = evt_q.restart;
  assign done_o     = evt_q.done;
  assign loop_end_o = evt_q.loop_end;
endmodule

// File: rtl/tx_loop_ctrl_chk.sv
module tx_loop_ctrl_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             seq_end_i,
  input logic             cont_en_i,
  input logic             cnt_en_i,
  input logic [CNT_W-1:0] loop_num_i,
  input logic             cnt_rst_i,
  input logic             active_o,
  input logic             restart_o,
  input logic             done_o,
  input logic             loop_end_o
);
  assert_evt_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({restart_o, done_o, loop_end_o}));

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!$past(cont_en_i) && !active_o));

  assert_restart_cont_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> ($past(cont_en_i) && active_o));

  assert_loop_end_lim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_end_o |-> ($past(cnt_en_i) && $past(loop_num_i) != '0 &&
                    !$past(cnt_rst_i) && !active_o));

  assert_start_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !active_o) |=> active_o);

  assert_stop_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!active_o && !restart_o && !done_o && !loop_end_o));

  assert_idle_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o || done_o || loop_end_o) |-> ($past(active_o) && $past(seq_end_i)));
endmodule

bind tx_loop_ctrl tx_loop_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .seq_end_i  (seq_end_i),
  .cont_en_i  (cont_en_i),
  .cnt_en_i   (cnt_en_i),
  .loop_num_i (loop_num_i),
  .cnt_rst_i  (cnt_rst_i),
  .active_o   (active_o),
  .restart_o  (restart_o),
  .done_o     (done_o),
  .loop_end_o (loop_end_o)
);

// File: tb/tx_loop_ctrl_tb_top.sv
module tx_loop_ctrl_tb_top;
  localparam int unsigned CNT_W = 3;
  // observed vector {active_o, restart_o, done_o, loop_end_o}
  localparam logic [3:0] V_IDLE = 4'b0000;
  localparam logic [3:0] V_RUN  = 4'b1000;
  localparam logic [3:0] V_RST  = 4'b1100;
  localparam logic [3:0] V_DONE = 4'b0010;
  localparam logic [3:0] V_LEND = 4'b0001;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, seq_end_i = 1'b0;
  logic cont_en_i = 1'b0, cnt_en_i = 1'b0, cnt_rst_i = 1'b0;
  logic [CNT_W-1:0] loop_num_i = '0;
  logic active_o, restart_o, done_o, loop_end_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  tx_loop_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .seq_end_i  (seq_end_i),
    .cont_en_i  (cont_en_i),
    .cnt_en_i   (cnt_en_i),
    .loop_num_i (loop_num_i),
    .cnt_rst_i  (cnt_rst_i),
    .active_o   (active_o),
    .restart_o  (restart_o),
    .done_o     (done_o),
    .loop_end_o (loop_end_o)
  );

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {active_o, restart_o, done_o, loop_end_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge; outputs are then valid at the next negedge
  task automatic cyc(input logic se, input logic st, input logic sp, input logic cr);
    seq_end_i = se; start_i = st; stop_i = sp; cnt_rst_i = cr;
    @(negedge clk_i);
    seq_end_i = 1'b0; start_i = 1'b0; stop_i = 1'b0; cnt_rst_i = 1'b0;
  endtask

  task automatic cfg(input logic c, input logic n, input int lim);
    cont_en_i = c; cnt_en_i = n; loop_num_i = CNT_W'(lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", V_IDLE);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", V_IDLE);

    // sweep: all enable pairs, every limit, nine ends per run
    for (int c = 0; c < 2; c++) begin
      for (int n = 0; n < 2; n++) begin
        for (int lim = 0; lim < 8; lim++) begin
          logic run;
          logic [3:0] exp;
          cfg(c[0], n[0], lim);
          cyc(0, 1, 0, 0);
          chk($sformatf("R2 start c=%0d n=%0d lim=%0d", c, n, lim), V_RUN);
          run = 1'b1;
          for (int k = 1; k <= 9; k++) begin
            if (!run) exp = V_IDLE;
            else if (c == 0) begin exp = V_DONE; run = 1'b0; end
            else if (n == 1 && lim != 0 && k == lim) begin exp = V_LEND; run = 1'b0; end
            else exp = V_RST;
            cyc(1, 0, 0, 0);
            chk($sformatf("R3 R4 R5 R6 R9 c=%0d n=%0d lim=%0d pass=%0d", c, n, lim, k), exp);
          end
          cyc(0, 0, 1, 0);
          chk("R8 stop ends sweep run", V_IDLE);
        end
      end
    end

    // R4 long unbounded run past counter saturation
    cfg(1, 0, 2);
    cyc(0, 1, 0, 0);
    for (int k = 0; k < 20; k++) begin
      cyc(1, 0, 0, 0);
      chk($sformatf("R4 long pass %0d", k), V_RST);
    end
    // enable counting mid-run: saturated count already past limit -> R10 rule
    cnt_en_i = 1'b1;
    cyc(1, 0, 0, 0);
    chk("R10 count enabled late", V_LEND);

    // R7 reset in mid run
    cfg(1, 1, 3);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); chk("R7 pass1", V_RST);
    cyc(1, 0, 0, 0); chk("R7 pass2", V_RST);
    cyc(0, 0, 0, 1); chk("R7 reset pulse", V_RUN);
    cyc(1, 0, 0, 0); chk("R7 post pass1", V_RST);
    cyc(1, 0, 0, 0); chk("R7 post pass2", V_RST);
    cyc(1, 0, 0, 0); chk("R7 post pass3 ends", V_LEND);

    // R7 reset coinciding with an end: that end not counted
    cfg(1, 1, 2);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 1); chk("R7 same-cycle end", V_RST);
    cyc(1, 0, 0, 0); chk("R7 same-cycle next", V_RST);
    cyc(1, 0, 0, 0); chk("R7 same-cycle final", V_LEND);

    // R7 with limit 1 and same-cycle reset
    cfg(1, 1, 1);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 1); chk("R7 lim1 voided pass", V_RST);
    cyc(1, 0, 0, 0); chk("R7 lim1 end", V_LEND);

    // R10 limit lowered mid run
    cfg(1, 1, 6);
    cyc(0, 1, 0, 0);
    for (int k = 1; k <= 3; k++) begin
      cyc(1, 0, 0, 0); chk($sformatf("R10 pass %0d", k), V_RST);
    end
    loop_num_i = 3'd2;
    cyc(0, 0, 0, 0); chk("R10 after lowering", V_RUN);
    cyc(1, 0, 0, 0); chk("R10 lowered limit ends", V_LEND);

    // R2 start while active ignored
    cfg(1, 1, 3);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); chk("R2 pass1", V_RST);
    cyc(1, 0, 0, 0); chk("R2 pass2", V_RST);
    cyc(0, 1, 0, 0); chk("R2 start while active", V_RUN);
    cyc(1, 0, 0, 0); chk("R2 count kept", V_LEND);

    // R11 start clears leftover count; R8 stop with end
    cfg(1, 1, 3);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); chk("R11 old pass1", V_RST);
    cyc(1, 0, 0, 0); chk("R11 old pass2", V_RST);
    cyc(1, 0, 1, 0); chk("R8 stop with end", V_IDLE);
    cyc(0, 1, 1, 0); chk("R8 stop beats start", V_IDLE);
    cyc(1, 0, 0, 0); chk("R9 end while idle", V_IDLE);
    cyc(0, 1, 0, 0); chk("R11 restart", V_RUN);
    cyc(1, 0, 0, 0); chk("R11 new pass1", V_RST);
    cyc(1, 0, 0, 0); chk("R11 new pass2", V_RST);
    cyc(1, 0, 0, 0); chk("R11 new pass3 ends", V_LEND);

    // R3 single shot ignores counting config
    cfg(0, 1, 1);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0); chk("R3 single shot done", V_DONE);
    cyc(0, 0, 0, 0); chk("R3 pulse one cycle", V_IDLE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule